// File: doc/BRIEF.md
# T1 Transmit Backplane Timing Generator

This block produces the backplane timing for one T1 transmit link when the link drives the timing. A half-bit tick at twice the 1.544 Mb/s line rate steps it through 193-bit frames: one framing bit, then 24 channels of eight bits. On every tick it emits either a rising or a falling edge strobe of the backplane clock, unless that bit is gapped. It also drives the clock level and a frame pulse. On the chosen sampling edge it captures the serial data and signaling inputs. Each captured bit is tagged with its channel and bit position.

With no gap option set the clock runs for every bit of the frame. With any gap option set the block runs in fractional mode. The clock is then removed for the whole of each selected channel, for only the last bit of each selected channel (56k use), and/or for the framing bit. The frame pulse marks every framing bit, or only the framing bit that opens a multiframe. Its polarity can be inverted, and it is updated on its own edge, so it can lead the sampled data by half a bit.

Top module: `t1tx_bp_timing`

## Requirements
- R1: While rst_n is low, edge_rise, edge_fall, bclk and smp_valid are 0, and fpulse equals fp_inv.
- R2: Each frame has 193 bits, each two ticks long (a rising then a falling half). Bit 0 is the framing bit, reported as smp_fbit=1 with smp_chan=0 and smp_bit=0. Bit 1+8c+k is channel c (0..23), bit k (0..7), where k=7 is the last bit of the channel.
- R3: With gap_chan, gap_bit8 and gap_fbit all 0, every tick yields an edge strobe: edge_rise on the first half of a bit and edge_fall on the second half.
- R4: With gap_chan=1, no edge strobe is produced during any bit of a channel whose mask bit is 1.
- R5: With gap_bit8=1 and gap_chan=0, only bit k=7 of a masked channel loses its edges.
- R6: With gap_fbit=1, no edge strobe is produced during the framing bit.
- R7: chan_mask is taken at the first half of the framing bit. A change later in a frame takes effect from the next frame.
- R8: With fp_mf=0 the pulse occurs every frame. With fp_mf=1 it occurs only for frame 0 of a 12-frame multiframe counted from reset.
- R9: fpulse is active low when fp_inv=1 and active high when fp_inv=0.
- R10: The frame pulse is active for one bit, changing only on the edge named by fp_edge (0 rising, 1 falling). It covers the framing bit. When fp_edge=1 and smp_edge=0 it starts on the falling half of the last bit of the previous frame, half a bit ahead.
- R11: smp_valid pulses on the edge named by smp_edge (0 rising, 1 falling) of every non-gapped bit, with the sdata and ssig values present on that tick. A gapped bit is not sampled.
- R12: bclk goes to 1 with each edge_rise and returns to 0 on the next tick; it stays 0 through gapped bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe per half bit period |
| gap_chan | input | 1 | Gap whole selected channels |
| gap_bit8 | input | 1 | Gap last bit of selected channels |
| gap_fbit | input | 1 | Gap the framing bit |
| fp_mf | input | 1 | Frame pulse per multiframe (1) or per frame (0) |
| fp_inv | input | 1 | Frame pulse active low |
| fp_edge | input | 1 | Frame pulse update edge, 0 rising, 1 falling |
| smp_edge | input | 1 | Data sampling edge, 0 rising, 1 falling |
| chan_mask | input | 24 | Channel select mask, bit c for channel c |
| sdata | input | 1 | Serial transmit data |
| ssig | input | 1 | Serial signaling bit |
| edge_rise | output | 1 | Rising edge strobe of the backplane clock |
| edge_fall | output | 1 | Falling edge strobe of the backplane clock |
| bclk | output | 1 | Backplane clock level |
| fpulse | output | 1 | Frame pulse |
| smp_valid | output | 1 | Sample strobe |
| smp_data | output | 1 | Sampled data bit |
| smp_sig | output | 1 | Sampled signaling bit |
| smp_fbit | output | 1 | Sample is the framing bit |
| smp_chan | output | 5 | Channel of the sample |
| smp_bit | output | 3 | Bit position within the channel |

## Verification
A wrong bit, channel or half position shows up on the very next tick. The gap pattern and the smp_chan/smp_bit tags no longer line up with the arithmetic position, and the frame pulse lands on a different bit. A frame counter that is off shows only at the next multiframe pulse, up to 12 frames later. A mask latched at the wrong moment shows within the same frame, as edges missing from or added to channels the mask does not yet cover. A stuck phase breaks the alternation of rise and fall strobes at once.

// File: rtl/t1tx_pkg.sv
// Shared types for the T1 transmit backplane timing generator.
// Assumes: half-bit ticks, first half of each bit is the rising clock half.
package t1tx_pkg;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    typedef struct packed {
        logic gap_chan;
        logic gap_bit8;
        logic gap_fbit;
    } gap_cfg_t;

endpackage

// File: rtl/t1tx_frame_ctr.sv
// Position counter: half-bit phase, framing-bit flag, channel, bit and frame.
// Assumes: tick is a one-cycle strobe; positions advance only on tick.
module t1tx_frame_ctr
    import t1tx_pkg::*;
#(
    parameter int CHANNELS    = 24,
    parameter int BITS_PER_CH = 8,
    parameter int MF_FRAMES   = 12,
    localparam int CH_W = $clog2(CHANNELS),
    localparam int BK_W = $clog2(BITS_PER_CH),
    localparam int FR_W = $clog2(MF_FRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output phase_e          phase,
    output logic            is_fbit,
    output logic [CH_W-1:0] ch,
    output logic [BK_W-1:0] bk,
    output logic [FR_W-1:0] frame,
    output logic            last_bit,
    output logic            frame_start
);
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(CHANNELS - 1);
    localparam logic [BK_W-1:0] BK_LAST = BK_W'(BITS_PER_CH - 1);
    localparam logic [FR_W-1:0] FR_LAST = FR_W'(MF_FRAMES - 1);

    // Advance half, bit, channel and frame counters on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_RISE;
            is_fbit <= 1'b1;
            ch      <= '0;
            bk      <= '0;
            frame   <= '0;
        end else if (tick) begin
            if (phase == PH_RISE) begin
                phase <= PH_FALL;
            end else begin
                phase <= PH_RISE;
                if (is_fbit) begin
                    is_fbit <= 1'b0;
                end else if (bk == BK_LAST) begin
                    bk <= '0;
                    if (ch == CH_LAST) begin
                        ch      <= '0;
                        is_fbit <= 1'b1;
                        frame   <= (frame == FR_LAST) ? '0 : frame + 1'b1;
                    end else begin
                        ch <= ch + 1'b1;
                    end
                end else begin
                    bk <= bk + 1'b1;
                end
            end
        end
    end

    // Decode the last bit of the frame and the frame-opening half.
    always_comb begin
        last_bit    = !is_fbit && (ch == CH_LAST) && (bk == BK_LAST);
        frame_start = is_fbit && (phase == PH_RISE);
    end

    p_fbit_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_fbit |-> (ch == '0 && bk == '0));
    p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ch <= CH_LAST);
    p_frame_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame <= FR_LAST);
    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase));
endmodule

// File: rtl/t1tx_gap_ctl.sv
// Gap decision: latches the channel mask at frame start and says whether the
// current bit has its clock removed.
// Assumes: frame_start, is_fbit, ch and bk describe the current half bit.
module t1tx_gap_ctl
    import t1tx_pkg::*;
#(
    parameter int CHANNELS    = 24,
    parameter int BITS_PER_CH = 8,
    localparam int CH_W = $clog2(CHANNELS),
    localparam int BK_W = $clog2(BITS_PER_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                frame_start,
    input  logic                is_fbit,
    input  logic [CH_W-1:0]     ch,
    input  logic [BK_W-1:0]     bk,
    input  logic [CHANNELS-1:0] chan_mask,
    input  gap_cfg_t            gcfg,
    output logic                gapped
);
    localparam logic [BK_W-1:0] BK_LAST = BK_W'(BITS_PER_CH - 1);

    logic [CHANNELS-1:0] mask_q;
    logic [CHANNELS-1:0] chan_gap;
    logic                on_last;

    // Capture the channel selection once per frame, at its first half bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (tick && frame_start) begin
            mask_q <= chan_mask;
        end
    end

    // Flag the last bit of a channel, where 56k gapping applies.
    always_comb on_last = (bk == BK_LAST);

    // Per-channel gap: whole channel, or its last bit only.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        always_comb chan_gap[c] = mask_q[c] && (gcfg.gap_chan || (gcfg.gap_bit8 && on_last));
    end

    // Select the framing-bit rule or the current channel's rule.
    always_comb gapped = is_fbit ? gcfg.gap_fbit : chan_gap[ch];

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_q) |-> $past(tick && frame_start));
    p_full_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gcfg == '0) |-> !gapped);
endmodule

// File: rtl/t1tx_fpulse_gen.sv
// Frame pulse generator: one-bit pulse around the framing bit, every frame or
// once per multiframe, updated on its own edge, with selectable polarity.
// Assumes: edge and type selects are static outside reset.
module t1tx_fpulse_gen
    import t1tx_pkg::*;
#(
    parameter int MF_FRAMES = 12,
    localparam int FR_W = $clog2(MF_FRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  phase_e          phase,
    input  logic            is_fbit,
    input  logic            last_bit,
    input  logic [FR_W-1:0] frame,
    input  logic            mf_mode,
    input  logic            fp_edge,
    input  logic            smp_edge,
    input  logic            fp_inv,
    output logic            fpulse
);
    localparam logic [FR_W-1:0] FR_LAST = FR_W'(MF_FRAMES - 1);

    logic act;
    logic lead;
    logic start;

    // Decide whether the pulse opens on this update edge.
    always_comb begin
        lead = fp_edge && !smp_edge;
        if (lead) begin
            start = last_bit && (!mf_mode || frame == FR_LAST);
        end else begin
            start = is_fbit && (!mf_mode || frame == '0);
        end
    end

    // Update the pulse state only on the selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
        end else if (tick && (phase == phase_e'(fp_edge))) begin
            act <= start;
        end
    end

    // Apply the output polarity.
    always_comb fpulse = act ^ fp_inv;

    p_fp_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> $past(tick));
    p_fp_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> ($past(phase) == phase_e'(fp_edge)));
endmodule

// File: rtl/t1tx_bus_io.sv
// Backplane drive: edge strobes, clock level and data/signaling sampling.
// Assumes: gapped and position inputs describe the half bit of this tick.
module t1tx_bus_io
    import t1tx_pkg::*;
#(
    parameter int CHANNELS    = 24,
    parameter int BITS_PER_CH = 8,
    localparam int CH_W = $clog2(CHANNELS),
    localparam int BK_W = $clog2(BITS_PER_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  phase_e          phase,
    input  logic            gapped,
    input  logic            smp_edge,
    input  logic            is_fbit,
    input  logic [CH_W-1:0] ch,
    input  logic [BK_W-1:0] bk,
    input  logic            sdata,
    input  logic            ssig,
    output logic            edge_rise,
    output logic            edge_fall,
    output logic            bclk,
    output logic            smp_valid,
    output logic            smp_data,
    output logic            smp_sig,
    output logic            smp_fbit,
    output logic [CH_W-1:0] smp_chan,
    output logic [BK_W-1:0] smp_bit
);
    logic live;
    logic take;

    // An edge exists on a tick of a non-gapped bit; sample on the chosen one.
    always_comb begin
        live = tick && !gapped;
        take = live && (phase == phase_e'(smp_edge));
    end

    // Drive the edge strobes and the clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_rise <= 1'b0;
            edge_fall <= 1'b0;
            bclk      <= 1'b0;
        end else begin
            edge_rise <= live && (phase == PH_RISE);
            edge_fall <= live && (phase == PH_FALL);
            if (tick) begin
                bclk <= live && (phase == PH_RISE);
            end
        end
    end

    // Capture data and signaling together with their position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= 1'b0;
            smp_sig   <= 1'b0;
            smp_fbit  <= 1'b0;
            smp_chan  <= '0;
            smp_bit   <= '0;
        end else begin
            smp_valid <= take;
            if (take) begin
                smp_data <= sdata;
                smp_sig  <= ssig;
                smp_fbit <= is_fbit;
                smp_chan <= ch;
                smp_bit  <= bk;
            end
        end
    end

    p_edge_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(edge_rise && edge_fall));
    p_rise_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        edge_rise |-> bclk);
    p_smp_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (smp_edge ? edge_fall : edge_rise));
    p_fbit_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_fbit) |-> (smp_chan == '0 && smp_bit == '0));
endmodule

// File: rtl/t1tx_bp_timing.sv
// Top: T1 transmit backplane timing generator for one link acting as timing
// master. Ties the position counter, gap control, frame pulse and bus drive.
// Assumes: half_tick is a one-cycle strobe at twice the line bit rate and
// the configuration inputs change only while rst_n is low (mask excepted).
module t1tx_bp_timing
    import t1tx_pkg::*;
#(
    parameter int CHANNELS    = 24,
    parameter int BITS_PER_CH = 8,
    parameter int MF_FRAMES   = 12,
    localparam int CH_W = $clog2(CHANNELS),
    localparam int BK_W = $clog2(BITS_PER_CH),
    localparam int FR_W = $clog2(MF_FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                half_tick,
    input  logic                gap_chan,
    input  logic                gap_bit8,
    input  logic                gap_fbit,
    input  logic                fp_mf,
    input  logic                fp_inv,
    input  logic                fp_edge,
    input  logic                smp_edge,
    input  logic [CHANNELS-1:0] chan_mask,
    input  logic                sdata,
    input  logic                ssig,
    output logic                edge_rise,
    output logic                edge_fall,
    output logic                bclk,
    output logic                fpulse,
    output logic                smp_valid,
    output logic                smp_data,
    output logic                smp_sig,
    output logic                smp_fbit,
    output logic [CH_W-1:0]     smp_chan,
    output logic [BK_W-1:0]     smp_bit
);
    phase_e          phase;
    logic            is_fbit;
    logic [CH_W-1:0] ch;
    logic [BK_W-1:0] bk;
    logic [FR_W-1:0] frame;
    logic            last_bit;
    logic            frame_start;
    logic            gapped;
    gap_cfg_t        gcfg;

    // Bundle the gap options.
    always_comb gcfg = '{gap_chan: gap_chan, gap_bit8: gap_bit8, gap_fbit: gap_fbit};

    t1tx_frame_ctr #(
        .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH), .MF_FRAMES(MF_FRAMES)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(half_tick), .phase(phase),
        .is_fbit(is_fbit), .ch(ch), .bk(bk), .frame(frame),
        .last_bit(last_bit), .frame_start(frame_start)
    );

    t1tx_gap_ctl #(
        .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH)
    ) u_gap (
        .clk(clk), .rst_n(rst_n), .tick(half_tick), .frame_start(frame_start),
        .is_fbit(is_fbit), .ch(ch), .bk(bk), .chan_mask(chan_mask),
        .gcfg(gcfg), .gapped(gapped)
    );

    t1tx_fpulse_gen #(
        .MF_FRAMES(MF_FRAMES)
    ) u_fp (
        .clk(clk), .rst_n(rst_n), .tick(half_tick), .phase(phase),
        .is_fbit(is_fbit), .last_bit(last_bit), .frame(frame),
        .mf_mode(fp_mf), .fp_edge(fp_edge), .smp_edge(smp_edge),
        .fp_inv(fp_inv), .fpulse(fpulse)
    );

    t1tx_bus_io #(
        .CHANNELS(CHANNELS), .BITS_PER_CH(BITS_PER_CH)
    ) u_io (
        .clk(clk), .rst_n(rst_n), .tick(half_tick), .phase(phase),
        .gapped(gapped), .smp_edge(smp_edge), .is_fbit(is_fbit),
        .ch(ch), .bk(bk), .sdata(sdata), .ssig(ssig),
        .edge_rise(edge_rise), .edge_fall(edge_fall), .bclk(bclk),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_sig(smp_sig),
        .smp_fbit(smp_fbit), .smp_chan(smp_chan), .smp_bit(smp_bit)
    );

    p_tick_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise || edge_fall) |-> $past(half_tick));
endmodule

// File: tb/t1tx_bp_timing_tb.sv
// Bench: sweeps gap, edge and polarity settings over two frames each, then
// runs full multiframes; expected values come from arithmetic on bit position.
module t1tx_bp_timing_tb;
    localparam int MF = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, half_tick = 1'b0;
    logic        gap_chan = 0, gap_bit8 = 0, gap_fbit = 0;
    logic        fp_mf = 0, fp_inv = 0, fp_edge = 0, smp_edge = 0;
    logic [23:0] chan_mask = '0;
    logic        sdata = 0, ssig = 0;
    logic        edge_rise, edge_fall, bclk, fpulse;
    logic        smp_valid, smp_data, smp_sig, smp_fbit;
    logic [4:0]  smp_chan;
    logic [2:0]  smp_bit;

    t1tx_bp_timing u_dut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .gap_chan(gap_chan), .gap_bit8(gap_bit8), .gap_fbit(gap_fbit),
        .fp_mf(fp_mf), .fp_inv(fp_inv), .fp_edge(fp_edge), .smp_edge(smp_edge),
        .chan_mask(chan_mask), .sdata(sdata), .ssig(ssig),
        .edge_rise(edge_rise), .edge_fall(edge_fall), .bclk(bclk),
        .fpulse(fpulse), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_sig(smp_sig), .smp_fbit(smp_fbit), .smp_chan(smp_chan),
        .smp_bit(smp_bit)
    );

    int n_chk = 0, n_err = 0, tcnt = 0;
    bit done = 0;

    // Reference position and state.
    int          mb, mh, mf;
    logic [23:0] mq, mask_first;
    logic        mact;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        half_tick = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(edge_rise == 0 && edge_fall == 0 && bclk == 0, "R1", "clk outs",
            {edge_rise, edge_fall, bclk}, 0);
        chk(smp_valid == 0 && fpulse == fp_inv, "R1", "valid/fpulse",
            {smp_valid, fpulse}, {1'b0, fp_inv});
        rst_n = 1'b1;
        mb = 0; mh = 0; mf = 0; mq = '0; mact = 0;
        mask_first = chan_mask;
    endtask

    task automatic step();
        int    c, k, ec, ek;
        bit    gp, er, ef, ev, start, fok0, fokn;
        string req;
        logic  d, s;
        if (mb == 0 && mh == 0) mq = chan_mask;
        c = (mb - 1) / 8;
        k = (mb - 1) % 8;
        if (mb == 0) gp = gap_fbit;
        else gp = mq[c] && (gap_chan || (gap_bit8 && k == 7));
        d = ((tcnt * 5 + 3) >> 2) & 1;
        s = (tcnt >> 3) & 1;
        @(negedge clk);
        sdata = d; ssig = s; half_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0;
        er = (mh == 0) && !gp;
        ef = (mh == 1) && !gp;
        if (mb == 0 && gap_fbit) req = "R6";
        else if (mb != 0 && mq != mask_first) req = "R7";
        else if (gp) req = gap_chan ? "R4" : "R5";
        else if (!(gap_chan || gap_bit8 || gap_fbit)) req = "R3";
        else req = "R4";
        chk(edge_rise == er && edge_fall == ef, req, "edges",
            {edge_rise, edge_fall}, {er, ef});
        chk(bclk == er, "R12", "bclk level", bclk, er);
        ev = (mh == int'(smp_edge)) && !gp;
        chk(smp_valid == ev, "R11", "smp_valid", smp_valid, ev);
        if (ev) begin
            chk(smp_data == d && smp_sig == s, "R11", "data/sig",
                {smp_data, smp_sig}, {d, s});
            ec = (mb == 0) ? 0 : c;
            ek = (mb == 0) ? 0 : k;
            chk(smp_fbit == (mb == 0) && smp_chan == ec && smp_bit == ek, "R2",
                "fbit/chan/bit", {smp_fbit, smp_chan, smp_bit},
                {(mb == 0), 5'(ec), 3'(ek)});
        end
        if (mh == int'(fp_edge)) begin
            fok0 = !fp_mf || mf == 0;
            fokn = !fp_mf || mf == MF - 1;
            if (fp_edge && !smp_edge) start = (mb == 192) && fokn;
            else start = (mb == 0) && fok0;
            mact = start;
        end
        req = fp_mf ? "R8" : (fp_inv ? "R9" : "R10");
        chk(fpulse == (mact ^ fp_inv), req, "fpulse", fpulse, mact ^ fp_inv);
        mh++;
        if (mh == 2) begin
            mh = 0;
            mb++;
            if (mb == 193) begin
                mb = 0;
                mf = (mf + 1) % MF;
            end
        end
        tcnt++;
    endtask

    initial begin
        for (int cfg = 0; cfg < 64; cfg++) begin
            gap_chan = cfg[0]; gap_bit8 = cfg[1]; gap_fbit = cfg[2];
            fp_edge = cfg[3]; smp_edge = cfg[4]; fp_inv = cfg[5];
            fp_mf = 1'b0;
            chan_mask = 24'hC3A596 ^ {cfg[5:0], cfg[5:0], cfg[5:0], cfg[5:0]};
            do_reset();
            for (int t = 0; t < 772; t++) begin
                if (t == 200) chan_mask = ~chan_mask;  // R7: mid-frame change
                step();
            end
        end
        for (int r = 0; r < 2; r++) begin
            // R8: multiframe pulse, plain and leading alignment
            gap_chan = 0; gap_bit8 = 1; gap_fbit = r[0];
            fp_mf = 1'b1; fp_edge = r[0]; smp_edge = 1'b0; fp_inv = r[0];
            chan_mask = 24'h0F0F0F;
            do_reset();
            for (int t = 0; t < 386 * (MF + 1); t++) step();
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule